// File: doc/BRIEF.md
# Segmented-PC Instruction Sequencer

This block runs a small six-opcode instruction stream on behalf of a simulated processor. It keeps a program counter made of a segment number and an offset, presents that counter as a logical address to an external translation unit, and reads back the instruction word or a fault flag. Start-I/O, wait-I/O and end instructions each leave the block as a single event pulse that carries the instruction's burst operand, an event code and an agent tag; after such an event the sequencer goes idle.

Jump and skip instructions never leave the block. A jump reloads the whole counter and fetching goes on. A skip word holds a counter that counts down each time it is run: while it is non-zero the sequencer writes the word back with the count one lower and steps over the jump that always follows it. Once the count is zero the sequencer falls through into that jump. A fault reported on any access ends the run at once, with no event and with the counter left where it was.

A run starts when a context load supplies a privilege mode and a starting counter while the block is idle. The mode goes out with every access so that the translation unit can pick its map, and it also decides the agent tag on events.

Top module: `instr_seq`

## Requirements
- R1: While reset is high and on the cycle after it, `busy`, `req_valid`, `req_we` and `evt_valid` are 0, and `cur_mode`, `mar_seg` and `mar_off` are 0.
- R2: A `ctx_load` pulse while idle copies `ctx_mode`, `ctx_seg` and `ctx_off` into the mode and counter and raises `busy` and `req_valid` on the next cycle. A `ctx_load` while busy has no effect on the run or on its result.
- R3: A word is `{opcode, operand}` with the opcode in the top `OP_W` bits. Opcode values are start-I/O 0, wait-I/O 1, request 2, jump 3, skip 4, end 5, and 6 or above for device operations. Jump operands hold the segment in their top `SEG_W` bits and the offset in their low `OFF_W` bits.
- R4: Start-I/O, wait-I/O and end produce exactly one `evt_valid` pulse on the cycle after the fetch response. `evt_code` is 0, 1 or 2 respectively and `evt_burst` is the operand. The offset then grows by 2 and the block goes idle.
- R5: `evt_agent` is 0 when the mode is 1 (boot) and is `term_id`+1 when the mode is 0.
- R6: A jump loads the segment and offset from its operand and fetches from there next.
- R7: A skip with a non-zero count issues a write (`req_we`=1) of the same word with the count lowered by one to the address it came from. After the write the offset grows by 2 and fetching continues.
- R8: A skip with a count of zero issues no write. The offset grows by 1, so the jump after it is fetched and run.
- R9: A fetch response with `rsp_fault`=1 ends the run with no event, and the counter keeps the faulting address.
- R10: A write-back response with `rsp_fault`=1 ends the run with no event, and the counter keeps the skip word's address.
- R11: Request (2) and device opcodes (6 and above) end the run with no event and with the counter unchanged.
- R12: `mar_seg`/`mar_off` always show the counter and `cur_mode` shows the mode. While idle with no load they stay constant.
- R13: A request holds `req_valid`, the address and the write data stable until `rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load | input | 1 | Context load: start a run (taken only when idle) |
| ctx_mode | input | 1 | Mode to load: 1 boot/privileged, 0 user |
| ctx_seg | input | SEG_W | Starting segment |
| ctx_off | input | OFF_W | Starting offset |
| term_id | input | TERM_W | Active terminal number for the agent tag |
| busy | output | 1 | High while a run is in progress |
| cur_mode | output | 1 | Current mode, seen by the translation unit |
| mar_seg | output | SEG_W | Address segment (the counter's segment) |
| mar_off | output | OFF_W | Address offset (the counter's offset) |
| req_valid | output | 1 | Access request to the translation unit |
| req_we | output | 1 | Request is a write-back of a skip word |
| req_wdata | output | WORD_W | Word to write back |
| rsp_valid | input | 1 | Access response |
| rsp_fault | input | 1 | Access faulted (segment or offset violation) |
| rsp_word | input | WORD_W | Instruction word read |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_code | output | 2 | 0 start-I/O, 1 wait-I/O, 2 program end |
| evt_burst | output | OPND_W | Burst operand of the event instruction |
| evt_agent | output | TERM_W+1 | Agent tag |

## Verification
Each access costs two cycles with the bench memory: the request appears one edge after the state change, and the response comes back half a cycle before the next edge. The event pulse is registered and rises on the edge that consumes the response; `busy` falls on that same edge, and the new counter shows on the address outputs from then on. The bench captures event pulses with a monitor at the falling edge and reads the final counter, the mode and the memory only after `busy` has dropped. No result is taken during the edge that produces it.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Opcode values as stored in instruction words (R3)
    localparam logic [7:0] OPC_SIO  = 8'd0;
    localparam logic [7:0] OPC_WIO  = 8'd1;
    localparam logic [7:0] OPC_REQ  = 8'd2;
    localparam logic [7:0] OPC_JUMP = 8'd3;
    localparam logic [7:0] OPC_SKIP = 8'd4;
    localparam logic [7:0] OPC_END  = 8'd5;

    typedef enum logic [1:0] {
        EVT_START = 2'd0,
        EVT_WAIT  = 2'd1,
        EVT_END   = 2'd2
    } evt_code_e;

    typedef enum logic [2:0] {
        CLS_EVENT,
        CLS_JUMP,
        CLS_SKIP,
        CLS_REQ,
        CLS_DEVICE
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        evt_code_e evt;
    } op_info_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE
    } seq_state_e;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r.evt = EVT_START;
        case (op)
            OPC_SIO:  r.cls = CLS_EVENT;
            OPC_WIO:  begin r.cls = CLS_EVENT; r.evt = EVT_WAIT; end
            OPC_END:  begin r.cls = CLS_EVENT; r.evt = EVT_END;  end
            OPC_JUMP: r.cls = CLS_JUMP;
            OPC_SKIP: r.cls = CLS_SKIP;
            OPC_REQ:  r.cls = CLS_REQ;
            default:  r.cls = CLS_DEVICE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int OPND_W = 12,
    localparam int WORD_W = OP_W + OPND_W
) (
    input  logic [WORD_W-1:0] word,
    output op_info_t          info,
    output logic [OPND_W-1:0] operand,
    output logic              count_zero
);

    logic [OP_W-1:0] opcode;

    assign opcode     = word[WORD_W-1 -: OP_W];
    assign operand    = word[OPND_W-1:0];
    assign count_zero = (operand == '0);

    generate
        if (OP_W >= 8) begin : g_wide_op
            // opcodes beyond the 8-bit range are all device operations
            always_comb begin
                if (opcode > OP_W'(255)) begin
                    info.cls = CLS_DEVICE;
                    info.evt = EVT_START;
                end else begin
                    info = classify(8'(opcode));
                end
            end
        end else begin : g_narrow_op
            assign info = classify(8'(opcode));
        end
    endgenerate

endmodule

// File: rtl/seq_ctx.sv
module seq_ctx #(
    parameter int SEG_W = 4,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             take_mode,
    input  logic [SEG_W-1:0] take_seg,
    input  logic [OFF_W-1:0] take_off,
    input  logic             jump,
    input  logic [SEG_W-1:0] jump_seg,
    input  logic [OFF_W-1:0] jump_off,
    input  logic             step,
    input  logic             step_two,
    output logic             mode,
    output logic [SEG_W-1:0] seg,
    output logic [OFF_W-1:0] off
);

    logic [OFF_W-1:0] step_amt;

    assign step_amt = step_two ? OFF_W'(2) : OFF_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= 1'b0;
            seg  <= '0;
            off  <= '0;
        end else if (take) begin
            mode <= take_mode;
            seg  <= take_seg;
            off  <= take_off;
        end else if (jump) begin
            seg  <= jump_seg;
            off  <= jump_off;
        end else if (step) begin
            off  <= off + step_amt;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int OPND_W = 12,
    parameter int TERM_W = 4,
    localparam int AGENT_W = TERM_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctx_load,
    input  logic               rsp_valid,
    input  logic               rsp_fault,
    input  op_info_t           info,
    input  logic [OPND_W-1:0]  operand,
    input  logic               count_zero,
    input  logic               mode,
    input  logic [TERM_W-1:0]  term_id,
    output logic               busy,
    output logic               req_valid,
    output logic               req_we,
    output logic               take,
    output logic               jump,
    output logic               step,
    output logic               step_two,
    output logic [OPND_W-1:0]  wr_operand,
    output logic               evt_valid,
    output logic [1:0]         evt_code,
    output logic [OPND_W-1:0]  evt_burst,
    output logic [AGENT_W-1:0] evt_agent
);

    seq_state_e state, state_nxt;
    logic       fire;
    logic       capture;

    assign busy      = (state != ST_IDLE);
    assign req_valid = (state == ST_FETCH) || (state == ST_WRITE);
    assign req_we    = (state == ST_WRITE);

    always_comb begin
        state_nxt = state;
        take      = 1'b0;
        jump      = 1'b0;
        step      = 1'b0;
        step_two  = 1'b0;
        fire      = 1'b0;
        capture   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ctx_load) begin
                    take      = 1'b1;
                    state_nxt = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rsp_valid) begin
                    if (rsp_fault) begin
                        state_nxt = ST_IDLE;
                    end else begin
                        case (info.cls)
                            CLS_EVENT: begin
                                fire      = 1'b1;
                                step      = 1'b1;
                                step_two  = 1'b1;
                                state_nxt = ST_IDLE;
                            end
                            CLS_JUMP: begin
                                jump      = 1'b1;
                                state_nxt = ST_FETCH;
                            end
                            CLS_SKIP: begin
                                if (count_zero) begin
                                    step      = 1'b1;
                                    state_nxt = ST_FETCH;
                                end else begin
                                    capture   = 1'b1;
                                    state_nxt = ST_WRITE;
                                end
                            end
                            default: state_nxt = ST_IDLE;
                        endcase
                    end
                end
            end
            ST_WRITE: begin
                if (rsp_valid) begin
                    if (rsp_fault) begin
                        state_nxt = ST_IDLE;
                    end else begin
                        step      = 1'b1;
                        step_two  = 1'b1;
                        state_nxt = ST_FETCH;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_operand <= '0;
        end else if (capture) begin
            wr_operand <= operand - OPND_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid <= 1'b0;
            evt_code  <= 2'd0;
            evt_burst <= '0;
            evt_agent <= '0;
        end else begin
            evt_valid <= fire;
            if (fire) begin
                evt_code  <= info.evt;
                evt_burst <= operand;
                evt_agent <= mode ? '0 : (AGENT_W'(term_id) + AGENT_W'(1));
            end
        end
    end

endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import seq_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 8,
    parameter int OP_W   = 4,
    parameter int TERM_W = 4,
    localparam int OPND_W  = SEG_W + OFF_W,
    localparam int WORD_W  = OP_W + OPND_W,
    localparam int AGENT_W = TERM_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctx_load,
    input  logic               ctx_mode,
    input  logic [SEG_W-1:0]   ctx_seg,
    input  logic [OFF_W-1:0]   ctx_off,
    input  logic [TERM_W-1:0]  term_id,
    output logic               busy,
    output logic               cur_mode,
    output logic [SEG_W-1:0]   mar_seg,
    output logic [OFF_W-1:0]   mar_off,
    output logic               req_valid,
    output logic               req_we,
    output logic [WORD_W-1:0]  req_wdata,
    input  logic               rsp_valid,
    input  logic               rsp_fault,
    input  logic [WORD_W-1:0]  rsp_word,
    output logic               evt_valid,
    output logic [1:0]         evt_code,
    output logic [OPND_W-1:0]  evt_burst,
    output logic [AGENT_W-1:0] evt_agent
);

    op_info_t          info;
    logic [OPND_W-1:0] operand;
    logic              count_zero;
    logic              take, jump, step, step_two;
    logic [OPND_W-1:0] wr_operand;

    seq_decode #(.OP_W(OP_W), .OPND_W(OPND_W)) u_dec (
        .word       (rsp_word),
        .info       (info),
        .operand    (operand),
        .count_zero (count_zero)
    );

    seq_ctx #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_mode (ctx_mode),
        .take_seg  (ctx_seg),
        .take_off  (ctx_off),
        .jump      (jump),
        .jump_seg  (operand[OPND_W-1 -: SEG_W]),
        .jump_off  (operand[OFF_W-1:0]),
        .step      (step),
        .step_two  (step_two),
        .mode      (cur_mode),
        .seg       (mar_seg),
        .off       (mar_off)
    );

    seq_ctrl #(.OPND_W(OPND_W), .TERM_W(TERM_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctx_load   (ctx_load),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .info       (info),
        .operand    (operand),
        .count_zero (count_zero),
        .mode       (cur_mode),
        .term_id    (term_id),
        .busy       (busy),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .take       (take),
        .jump       (jump),
        .step       (step),
        .step_two   (step_two),
        .wr_operand (wr_operand),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code),
        .evt_burst  (evt_burst),
        .evt_agent  (evt_agent)
    );

    assign req_wdata = {OP_W'(OPC_SKIP), wr_operand};

endmodule

// File: rtl/seq_chk.sv
module seq_chk
    import seq_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 8,
    parameter int OP_W   = 4,
    parameter int TERM_W = 4,
    localparam int OPND_W  = SEG_W + OFF_W,
    localparam int WORD_W  = OP_W + OPND_W,
    localparam int AGENT_W = TERM_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               ctx_load,
    input logic               busy,
    input logic               cur_mode,
    input logic [SEG_W-1:0]   mar_seg,
    input logic [OFF_W-1:0]   mar_off,
    input logic               req_valid,
    input logic               req_we,
    input logic [WORD_W-1:0]  req_wdata,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic               evt_valid,
    input logic [AGENT_W-1:0] evt_agent
);

    AST_START_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctx_load)); // R2

    AST_EVT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid); // R4

    AST_EVT_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (!busy && !req_valid)); // R4

    AST_BOOT_AGENT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && cur_mode) |-> (evt_agent == '0)); // R5

    AST_WRITE_IS_SKIP: assert property (@(posedge clk) disable iff (rst)
        req_we |-> (req_valid && (req_wdata[WORD_W-1 -: OP_W] == OP_W'(OPC_SKIP)))); // R7

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_valid && rsp_fault) |=> (!busy && !evt_valid)); // R9

    AST_IDLE_PC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctx_load) |=> ($stable(mar_seg) && $stable(mar_off) && $stable(cur_mode))); // R12

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(mar_seg) && $stable(mar_off)
                                       && $stable(req_we) && $stable(req_wdata))); // R13

endmodule

bind instr_seq seq_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .OP_W(OP_W), .TERM_W(TERM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctx_load  (ctx_load),
    .busy      (busy),
    .cur_mode  (cur_mode),
    .mar_seg   (mar_seg),
    .mar_off   (mar_off),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .evt_valid (evt_valid),
    .evt_agent (evt_agent)
);

// File: tb/instr_seq_tb.sv
`timescale 1ns/1ps
module instr_seq_tb;

    localparam int SEG_W = 4, OFF_W = 8, OP_W = 4, TERM_W = 4;
    localparam int OPND_W = SEG_W + OFF_W;
    localparam int WORD_W = OP_W + OPND_W;
    localparam int AGENT_W = TERM_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctx_load = 1'b0, ctx_mode = 1'b0;
    logic [SEG_W-1:0] ctx_seg = '0;
    logic [OFF_W-1:0] ctx_off = '0;
    logic [TERM_W-1:0] term_id = '0;
    logic busy, cur_mode, req_valid, req_we;
    logic [SEG_W-1:0] mar_seg;
    logic [OFF_W-1:0] mar_off;
    logic [WORD_W-1:0] req_wdata;
    logic rsp_valid = 1'b0, rsp_fault = 1'b0;
    logic [WORD_W-1:0] rsp_word = '0;
    logic evt_valid;
    logic [1:0] evt_code;
    logic [OPND_W-1:0] evt_burst;
    logic [AGENT_W-1:0] evt_agent;

    always #5 clk = ~clk;

    instr_seq #(.SEG_W(SEG_W), .OFF_W(OFF_W), .OP_W(OP_W), .TERM_W(TERM_W)) u_dut (
        .clk(clk), .rst(rst), .ctx_load(ctx_load), .ctx_mode(ctx_mode),
        .ctx_seg(ctx_seg), .ctx_off(ctx_off), .term_id(term_id),
        .busy(busy), .cur_mode(cur_mode), .mar_seg(mar_seg), .mar_off(mar_off),
        .req_valid(req_valid), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_word(rsp_word),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_burst(evt_burst),
        .evt_agent(evt_agent)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // Memory behind a translation model: segments 0..2 hold 32 words each,
    // segment 2 is read-only; the mode picks one of two banks.
    logic [WORD_W-1:0] mem [0:255];

    function automatic int idx(input logic m, input int s, input int o);
        return (int'(m) << 7) | ((s & 3) << 5) | (o & 31);
    endfunction

    function automatic logic [WORD_W-1:0] wrd(input int op, input int opnd);
        return {OP_W'(op), OPND_W'(opnd)};
    endfunction

    function automatic int addr_opnd(input int s, input int o);
        return (s << OFF_W) | o;
    endfunction

    always @(negedge clk) begin
        if (rsp_valid) begin
            rsp_valid <= 1'b0;
        end else if (req_valid) begin
            logic flt;
            flt = (mar_seg >= 3) || (mar_off >= 32) || (req_we && mar_seg == 2);
            rsp_fault <= flt;
            if (!flt) begin
                rsp_word <= mem[idx(cur_mode, int'(mar_seg), int'(mar_off))];
                if (req_we) mem[idx(cur_mode, int'(mar_seg), int'(mar_off))] = req_wdata;
            end
            rsp_valid <= 1'b1;
        end
    end

    int ev_cnt = 0;
    int ev_code, ev_burst, ev_agent;
    always @(negedge clk) begin
        if (evt_valid) begin
            ev_cnt++;
            ev_code  = int'(evt_code);
            ev_burst = int'(evt_burst);
            ev_agent = int'(evt_agent);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic m, input int s, input int o, input int t);
        int waited;
        @(negedge clk);
        ctx_load = 1'b1; ctx_mode = m; ctx_seg = SEG_W'(s); ctx_off = OFF_W'(o);
        term_id = TERM_W'(t);
        @(negedge clk);
        ctx_load = 1'b0;
        waited = 0;
        while (busy && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (busy) check("R2 run finished", 1, 0);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] burst;
        logic        priv;
        logic [3:0]  term;
        logic        has_ev;
        logic [1:0]  code;
        logic [7:0]  end_off;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{4'd0, 12'd7,    1'b1, 4'd3,  1'b1, 2'd0, 8'd6},
        '{4'd1, 12'd300,  1'b0, 4'd5,  1'b1, 2'd1, 8'd6},
        '{4'd5, 12'd0,    1'b0, 4'd15, 1'b1, 2'd2, 8'd6},
        '{4'd2, 12'h123,  1'b0, 4'd1,  1'b0, 2'd0, 8'd4},
        '{4'd9, 12'd50,   1'b1, 4'd0,  1'b0, 2'd0, 8'd4}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 req_valid", int'(req_valid), 0);
        check("R1 evt_valid", int'(evt_valid), 0);
        check("R1 mar", int'({mar_seg, mar_off}), 0);
        check("R1 mode", int'(cur_mode), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 req_we after reset", int'(req_we), 0);

        // Table: one instruction at (0,4) of the selected bank (R3 R4 R5 R11)
        for (int v = 0; v < 5; v++) begin
            mem[idx(VEC[v].priv, 0, 4)] = wrd(int'(VEC[v].op), int'(VEC[v].burst));
            base = ev_cnt;
            run(VEC[v].priv, 0, 4, int'(VEC[v].term));
            check($sformatf("R4 R11 vec%0d event count", v), ev_cnt - base, int'(VEC[v].has_ev));
            check($sformatf("R4 R11 vec%0d offset", v), int'(mar_off), int'(VEC[v].end_off));
            check($sformatf("R11 vec%0d segment", v), int'(mar_seg), 0);
            if (VEC[v].has_ev) begin
                check($sformatf("R4 vec%0d code", v), ev_code, int'(VEC[v].code));
                check($sformatf("R4 vec%0d burst", v), ev_burst, int'(VEC[v].burst));
                check($sformatf("R5 vec%0d agent", v), ev_agent,
                      VEC[v].priv ? 0 : int'(VEC[v].term) + 1);
            end
        end

        // R6: jump across segments, then start-I/O
        mem[idx(0, 0, 0)] = wrd(3, addr_opnd(1, 5));
        mem[idx(0, 1, 5)] = wrd(0, 11);
        base = ev_cnt;
        run(0, 0, 0, 2);
        check("R6 event count", ev_cnt - base, 1);
        check("R6 burst after jump", ev_burst, 11);
        check("R6 segment", int'(mar_seg), 1);
        check("R6 offset", int'(mar_off), 7);
        check("R5 user agent", ev_agent, 3);

        // R7: skip with count 1 writes back 0, steps over the jump
        mem[idx(0, 0, 0)]  = wrd(4, 1);
        mem[idx(0, 0, 1)]  = wrd(3, addr_opnd(0, 10));
        mem[idx(0, 0, 2)]  = wrd(5, 3);
        mem[idx(0, 0, 10)] = wrd(1, 4);
        base = ev_cnt;
        run(0, 0, 0, 0);
        check("R7 event count", ev_cnt - base, 1);
        check("R7 end event after skip", ev_code, 2);
        check("R7 burst", ev_burst, 3);
        check("R7 offset", int'(mar_off), 4);
        check("R7 written word", int'(mem[idx(0, 0, 0)]), int'(wrd(4, 0)));

        // R8: count now zero, falls into jump to (0,10)
        base = ev_cnt;
        run(0, 0, 0, 0);
        check("R8 event count", ev_cnt - base, 1);
        check("R8 wait event via jump", ev_code, 1);
        check("R8 burst", ev_burst, 4);
        check("R8 offset", int'(mar_off), 12);
        check("R8 word unchanged", int'(mem[idx(0, 0, 0)]), int'(wrd(4, 0)));

        // R9: fetch fault at start and after a jump
        base = ev_cnt;
        run(0, 0, 40, 0);
        check("R9 no event", ev_cnt - base, 0);
        check("R9 offset kept", int'(mar_off), 40);
        mem[idx(0, 0, 20)] = wrd(3, addr_opnd(3, 0));
        base = ev_cnt;
        run(0, 0, 20, 0);
        check("R9 no event after jump", ev_cnt - base, 0);
        check("R9 faulting segment kept", int'(mar_seg), 3);
        check("R9 faulting offset kept", int'(mar_off), 0);

        // R10: write-back into read-only segment faults
        mem[idx(0, 2, 0)] = wrd(4, 5);
        base = ev_cnt;
        run(0, 2, 0, 0);
        check("R10 no event", ev_cnt - base, 0);
        check("R10 segment", int'(mar_seg), 2);
        check("R10 offset", int'(mar_off), 0);
        check("R10 memory untouched", int'(mem[idx(0, 2, 0)]), int'(wrd(4, 5)));

        // R2: load while busy is ignored
        mem[idx(0, 0, 24)] = wrd(1, 21);
        base = ev_cnt;
        @(negedge clk);
        ctx_load = 1'b1; ctx_mode = 1'b0; ctx_seg = '0; ctx_off = 8'd24; term_id = 4'd1;
        @(negedge clk);
        check("R2 busy after load", int'(busy), 1);
        ctx_off = 8'd40; ctx_mode = 1'b1;
        @(negedge clk);
        ctx_load = 1'b0;
        repeat (20) @(negedge clk);
        check("R2 event count", ev_cnt - base, 1);
        check("R2 burst", ev_burst, 21);
        check("R2 offset", int'(mar_off), 26);
        check("R2 mode kept", int'(cur_mode), 0);

        // R5 R12: boot mode selects the other bank, agent 0
        mem[idx(1, 0, 4)] = wrd(0, 9);
        mem[idx(0, 0, 4)] = wrd(5, 2);
        base = ev_cnt;
        run(1, 0, 4, 7);
        check("R12 mode shown", int'(cur_mode), 1);
        check("R12 boot bank burst", ev_burst, 9);
        check("R5 boot agent", ev_agent, 0);
        repeat (5) @(negedge clk);
        check("R12 idle offset steady", int'(mar_off), 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule